// File: doc/BRIEF.md
# Byte-Packing Write Queue for a Time-Slotted Memory

This block takes a stream of byte, 16-bit and 32-bit writes from a processor core and packs them into a queue of 32-bit entries. Consecutive writes fill consecutive memory bytes from a start address. The memory is shared through a slot index that rotates over the low four bits of the long address. An entry goes to memory only in a cycle where the slot index names its address. Because addresses are consecutive, a run of complete entries leaves on back-to-back cycles once the slot reaches the oldest one.

A partly filled entry is never written on its own. It stays in the block until its last byte lane arrives, or until the core restarts the block with a new start command. A restart forces the partial entry out with byte enables on only its valid lanes. The block then holds the core off until that entry has reached memory. The write region can be limited to a number of 64-byte blocks, after which the address returns to the start. A block count of zero lets the address run on.

Top module: `slot_write_packer`

## Requirements
- R1: Written bytes are placed at consecutive byte addresses starting at the start long address. Byte address a maps to lane a mod 4 of long a/4, lane 0 being mem_wdata_o[7:0]. Entries reach memory in the order they were filled, each exactly once.
- R2: A word (wr_data_i[15:0]) or long (wr_data_i[31:0]) stores its low byte first. When it crosses a long boundary it is split across two consecutive entries. If several strobes are high, long beats word and word beats byte.
- R3: An entry is written to memory only once lane 3 has been filled, and then with mem_be_o = 4'b1111. A partial entry produces no memory write while no restart occurs.
- R4: An entry is written in the first cycle, from the cycle after it completes, in which slot_i equals bits [3:0] of its long address and it is the oldest entry held. mem_we_o is high for exactly those cycles.
- R5: The queue holds 21 complete entries. stall_o is high whenever 21 are held. A write offered while stall_o is high is ignored.
- R6: A restart while lanes 0..k-1 of an entry are filled (k = 1..3) writes that entry after all older entries, at its own address, with mem_be_o bits 0..k-1 set and the others clear. New data then starts at the new start address, lane 0.
- R7: After a restart that forces out a partial entry, stall_o stays high until that entry has been written and the queue is empty. A restart with no partial entry raises stall_o only in its own cycle.
- R8: With a block count N > 0, the long address after start+16N-1 is start again.
- R9: With a block count of zero the long address keeps incrementing and never returns to the start.
- R10: stall_o is high in any cycle with start_i high, and a write in that cycle is ignored. A start_i while stall_o is high because of R7 is ignored.
- R11: After reset stall_o and mem_we_o are low, the start long address is 0, and no wrap limit applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart: load start address and block count |
| start_addr_i | input | ADDR_W-2 | Start long address |
| start_blocks_i | input | BLK_W | Region size in 64-byte blocks, 0 = no wrap |
| wr_byte_i | input | 1 | Write one byte |
| wr_word_i | input | 1 | Write two bytes |
| wr_long_i | input | 1 | Write four bytes |
| wr_data_i | input | 32 | Write data, low byte first |
| stall_o | output | 1 | Write or restart not taken this cycle |
| slot_i | input | 4 | Rotating memory slot index |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W-2 | Memory long address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables |

## Verification
The burst side can remove the oldest entry in the same cycle that a completing write adds a new one, or that a forced-out partial entry is queued behind older ones. Both collisions are provoked by random mixes of byte, word and long writes against a rotating slot, with occasional restarts and stretches where the slot is held still so the queue fills. Each cycle, a bench model built byte by byte from the requirements predicts stall_o, whether memory is written, and the address, enables and enabled data lanes. That prediction is compared to the outputs, so a lost, doubled or reordered entry at a collision shows up as a mismatch.

// File: rtl/slot_write_packer.sv
`timescale 1ns/1ps
module slot_write_packer #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 10,
  parameter int DEPTH  = 21
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-3:0] start_addr_i,
  input  logic [BLK_W-1:0]  start_blocks_i,
  input  logic              wr_byte_i,
  input  logic              wr_word_i,
  input  logic              wr_long_i,
  input  logic [31:0]       wr_data_i,
  output logic              stall_o,
  input  logic [3:0]        slot_i,
  output logic              mem_we_o,
  output logic [ADDR_W-3:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_be_o
);
  localparam int LA_W = ADDR_W - 2;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int PW   = $clog2(DEPTH);

  logic [31:0]     q_data [DEPTH];
  logic [3:0]      q_be   [DEPTH];
  logic [LA_W-1:0] q_la   [DEPTH];
  logic [PW-1:0]   rd_p, wr_p;
  logic [CW-1:0]   count;

  logic [LA_W-1:0] asm_la, base_la, end_la, fl_la;
  logic [31:0]     asm_data, fl_data, cur_data, nxt_data;
  logic [3:0]      fl_be;
  logic [1:0]      pos;
  logic [2:0]      lane;
  logic            wrap_en, fl_pend, busy;

  wire full = (count == CW'(DEPTH));
  assign stall_o = full | busy | start_i;

  wire [2:0] nbytes = wr_long_i ? 3'd4 : wr_word_i ? 3'd2 : wr_byte_i ? 3'd1 : 3'd0;
  wire       wr_ok    = (nbytes != 3'd0) && !stall_o;
  wire       start_ok = start_i && !busy;
  wire [2:0] endpos   = {1'b0, pos} + nbytes;
  wire       wr_push  = wr_ok && endpos[2];
  wire       fl_push  = fl_pend && !full;
  wire       push     = wr_push | fl_push;
  wire       pop      = (count != '0) && (slot_i == q_la[rd_p][3:0]);

  wire [LA_W-1:0] la_inc  = asm_la + 1'b1;
  wire [LA_W-1:0] next_la = (wrap_en && la_inc == end_la) ? base_la : la_inc;

  always_comb begin
    cur_data = asm_data;
    nxt_data = '0;
    lane     = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < nbytes) begin
        lane = {1'b0, pos} + 3'(k);
        if (lane[2]) nxt_data[{lane[1:0], 3'b000} +: 8] = wr_data_i[k*8 +: 8];
        else         cur_data[{lane[1:0], 3'b000} +: 8] = wr_data_i[k*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_data[wr_p] <= fl_push ? fl_data : cur_data;
      q_be[wr_p]   <= fl_push ? fl_be   : 4'hF;
      q_la[wr_p]   <= fl_push ? fl_la   : asm_la;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0; wr_p <= '0; count <= '0;
      asm_la <= '0; base_la <= '0; end_la <= '0; wrap_en <= 1'b0;
      asm_data <= '0; pos <= '0;
      fl_la <= '0; fl_data <= '0; fl_be <= '0; fl_pend <= 1'b0; busy <= 1'b0;
    end else begin
      if (push) wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (busy && !fl_pend && count == '0) busy <= 1'b0;
      if (fl_push) fl_pend <= 1'b0;
      if (start_ok) begin
        base_la  <= start_addr_i;
        end_la   <= start_addr_i + (LA_W'(start_blocks_i) << 4);
        wrap_en  <= (start_blocks_i != '0);
        asm_la   <= start_addr_i;
        asm_data <= '0;
        pos      <= '0;
        if (pos != 2'd0) begin
          fl_pend <= 1'b1;
          busy    <= 1'b1;
          fl_la   <= asm_la;
          fl_data <= asm_data;
          fl_be   <= ~(4'hF << pos);
        end
      end else if (wr_ok) begin
        asm_data <= wr_push ? nxt_data : cur_data;
        pos      <= endpos[1:0];
        if (wr_push) asm_la <= next_la;
      end
    end
  end

  assign mem_we_o    = pop;
  assign mem_addr_o  = q_la[rd_p];
  assign mem_wdata_o = q_data[rd_p];
  assign mem_be_o    = q_be[rd_p];

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !mem_we_o) |=> full);
  // R3
  partial_only_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_be_o != 4'hF) |-> busy);
  // R7
  flush_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (count == '0));
endmodule

// File: tb/slot_write_packer_tb_top.sv
`timescale 1ns/1ps
module slot_write_packer_tb_top;
  localparam int DEPTH = 21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, wr_byte_i = 0, wr_word_i = 0, wr_long_i = 0;
  logic [17:0] start_addr_i = '0;
  logic [9:0]  start_blocks_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  slot_i = '0;
  logic stall_o, mem_we_o;
  logic [17:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [3:0]  mem_be_o;

  always #2.5 clk = ~clk;

  slot_write_packer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_blocks_i(start_blocks_i), .wr_byte_i(wr_byte_i), .wr_word_i(wr_word_i),
    .wr_long_i(wr_long_i), .wr_data_i(wr_data_i), .stall_o(stall_o), .slot_i(slot_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o));

  int n_chk = 0, n_err = 0, n_we = 0;
  bit done = 0;

  // bench model of expected entries
  logic [17:0] e_la [64];
  logic [31:0] e_data [64];
  logic [3:0]  e_be [64];
  int hd = 0, tl = 0, mc = 0;
  logic [17:0] m_la = '0, m_base = '0, m_end = '0, f_la = '0;
  logic [31:0] m_data = '0, f_data = '0;
  logic [3:0]  f_be = '0;
  int m_pos = 0;
  bit m_wrap = 0, m_busy = 0, m_flp = 0;
  bit freeze = 0, last_stall = 0;
  logic [3:0]  slot_cnt = '0, slot_hold = '0;
  logic [17:0] last_addr = '0;
  logic [31:0] last_data = '0;
  logic [3:0]  last_be = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m32(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [17:0] nextla(input logic [17:0] la);
    if (m_wrap && (la + 18'd1) == m_end) return m_base;
    return la + 18'd1;
  endfunction

  task automatic qpush(input logic [17:0] la, input logic [31:0] d, input logic [3:0] be);
    e_la[tl] = la; e_data[tl] = d; e_be[tl] = be;
    tl = (tl + 1) % 64; mc++;
  endtask

  task automatic step(input bit st, input logic [17:0] sa, input logic [9:0] sb,
                      input int nb, input logic [31:0] d);
    bit exp_stall, exp_we, b0, f0;
    int c0;
    string tg;
    @(negedge clk);
    start_i = st; start_addr_i = sa; start_blocks_i = sb;
    wr_byte_i = (nb == 1); wr_word_i = (nb == 2); wr_long_i = (nb == 4);
    wr_data_i = d;
    slot_i = freeze ? slot_hold : slot_cnt;
    #1;
    c0 = mc; b0 = m_busy; f0 = m_flp;
    exp_stall = (c0 == DEPTH) || b0 || st;
    if (st) tg = "R10 stall"; else if (b0) tg = "R7 stall"; else tg = "R5 stall";
    chk(tg, 64'(stall_o), 64'(exp_stall));
    last_stall = stall_o;
    exp_we = (c0 != 0) && (slot_i == e_la[hd][3:0]);
    chk("R4 write strobe", 64'(mem_we_o), 64'(exp_we));
    if (mem_we_o) begin
      n_we++;
      last_addr = mem_addr_o; last_data = mem_wdata_o; last_be = mem_be_o;
    end
    if (exp_we && mem_we_o) begin
      chk("R4 address", 64'(mem_addr_o), 64'(e_la[hd]));
      if (e_be[hd] == 4'hF) tg = "R3 enables"; else tg = "R6 enables";
      chk(tg, 64'(mem_be_o), 64'(e_be[hd]));
      chk("R1 data", 64'(mem_wdata_o & m32(e_be[hd])), 64'(e_data[hd] & m32(e_be[hd])));
      hd = (hd + 1) % 64; mc--;
    end
    if (b0 && !f0 && c0 == 0) m_busy = 0;
    if (f0 && c0 < DEPTH) begin qpush(f_la, f_data, f_be); m_flp = 0; end
    if (st && !b0) begin
      if (m_pos != 0) begin
        f_la = m_la; f_data = m_data; f_be = 4'((1 << m_pos) - 1);
        m_flp = 1; m_busy = 1;
      end
      m_base = sa; m_end = sa + (18'(sb) << 4); m_wrap = (sb != 0);
      m_la = sa; m_data = '0; m_pos = 0;
    end else if (nb != 0 && !exp_stall) begin
      for (int k = 0; k < nb; k++) begin
        m_data[m_pos*8 +: 8] = d[k*8 +: 8];
        if (m_pos == 3) begin
          qpush(m_la, m_data, 4'hF);
          m_data = '0; m_la = nextla(m_la); m_pos = 0;
        end else m_pos++;
      end
    end
    slot_cnt = slot_cnt + 4'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int snap, nb, r;
    r = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 reset stall", 64'(stall_o), 64'd0);
    chk("R11 reset write", 64'(mem_we_o), 64'd0);

    // R3: partial entry held
    step(1, 18'h80, 0, 0, 0);
    snap = n_we;
    step(0, 0, 0, 1, 32'h11); step(0, 0, 0, 1, 32'h22); step(0, 0, 0, 1, 32'h33);
    idle(40);
    chk("R3 partial held", 64'(n_we - snap), 64'd0);
    step(0, 0, 0, 1, 32'h44);
    idle(20);
    chk("R3 full written", 64'(n_we - snap), 64'd1);
    chk("R1 assembled", 64'(last_data), 64'h44332211);

    // R2: unaligned long split
    step(0, 0, 0, 1, 32'hAA);
    step(0, 0, 0, 4, 32'h44332211);
    idle(20);
    chk("R2 split", 64'(last_data), 64'h332211AA);
    chk("R2 address", 64'(last_addr), 64'h81);
    step(0, 0, 0, 2, 32'h6655);

    // R6/R7: restart with partial (lanes 0..2)
    step(1, 18'h90, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R7 busy after flush restart", 64'(last_stall), 64'd1);
    idle(20);
    chk("R6 flush enables", 64'(last_be), 64'h7);
    chk("R6 flush data", 64'(last_data & 32'h00FFFFFF), 64'h00665544);
    chk("R6 flush address", 64'(last_addr), 64'h82);

    // R7: restart without partial
    step(1, 18'h90, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R7 no busy when clean", 64'(last_stall), 64'd0);

    // R10: write with start dropped
    step(1, 18'h90, 0, 1, 32'hEE);
    chk("R10 start cycle stall", 64'(last_stall), 64'd1);
    step(0, 0, 0, 1, 32'h01); step(0, 0, 0, 1, 32'h02);
    step(0, 0, 0, 1, 32'h03); step(0, 0, 0, 1, 32'h04);
    idle(20);
    chk("R10 dropped byte", 64'(last_data), 64'h04030201);

    // R8: one 64-byte block wraps
    step(1, 18'h40, 10'd1, 0, 0);
    for (int i = 0; i < 17; i++) step(0, 0, 0, 4, 32'(i));
    idle(40);
    chk("R8 wrap address", 64'(last_addr), 64'h40);
    chk("R8 wrap data", 64'(last_data), 64'd16);

    // R9: no wrap
    step(1, 18'h40, 10'd0, 0, 0);
    for (int i = 0; i < 17; i++) step(0, 0, 0, 4, 32'(i));
    idle(40);
    chk("R9 no wrap address", 64'(last_addr), 64'h50);

    // R5: fill queue with slot held away from front
    step(1, 18'h0, 10'd0, 0, 0);
    freeze = 1; slot_hold = 4'd5; snap = n_we;
    for (int i = 0; i < 25; i++) step(0, 0, 0, 4, 32'hC0DE0000 + 32'(i));
    chk("R5 stall when full", 64'(last_stall), 64'd1);
    freeze = 0;
    idle(80);
    chk("R5 entries kept", 64'(n_we - snap), 64'd21);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(63) == 0) begin
        freeze = !freeze; slot_hold = 4'($urandom_range(15));
      end
      r = $urandom_range(9);
      nb = (r < 3) ? 1 : (r < 5) ? 2 : (r < 8) ? 4 : 0;
      if ($urandom_range(199) == 0)
        step(1, 18'($urandom_range(255)), 10'($urandom_range(3)), nb, $urandom);
      else
        step(0, 0, 0, nb, $urandom);
    end
    freeze = 0;
    idle(120);
    chk("R4 all entries written", 64'(mc), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule